// File: doc/BRIEF.md
# Programmable Propagate-Generate ALU

This block is an N-bit arithmetic and logic unit built around one carry chain. Each bit slice computes a propagate term and a generate term. The operation select decides how those terms are formed, so addition, subtraction and every two-input bitwise function share the same chain and the same final XOR. In logic mode the propagate term comes from a 4-entry truth table that the caller supplies. The generate term and the carry-in are both held at zero, so the carry chain stays quiet and the result equals the propagate term. Subtraction needs no inverter mux in front of the chain. Instead the slice uses different propagate and generate equations and the carry-in is set to 1.

Requests enter through a valid/ready port: an operation is taken on a clock edge where `in_valid` and `in_ready` are both high. The result sits in a single output register and is offered with `out_valid`. It leaves on an edge where `out_valid` and `out_ready` are both high. While the consumer holds `out_ready` low, the register keeps its contents and `in_ready` stays low, so nothing new is accepted. Inputs may change freely while they are not being accepted. A new request can be taken on the same edge that the pending result is consumed, which gives one operation per cycle when the consumer is always ready.

Top module: `pg_alu`

## Requirements
- R1: With `op` = 2'b00 (add), the captured `res` equals (a + b) mod 2^W and `cout` equals bit W of the full sum.
- R2: With `op` = 2'b01 (subtract), `res` equals (a − b) mod 2^W and `cout` is 1 exactly when a ≥ b as unsigned numbers.
- R3: With `op` = 2'b10 (logic), each result bit i equals `fcode[3 − {a[i],b[i]}]`. The 4-bit code therefore lists outputs for the pairs 00, 01, 10, 11 from its most significant bit down, so 4'b0110 gives XOR, 4'b0001 gives AND and 4'b0111 gives OR. All 16 codes are valid.
- R4: In logic mode `cout` is 0.
- R5: `fcode` has no effect on `res`, `cout` or `err` when `op` is add or subtract.
- R6: `op` = 2'b11 is illegal: it yields `res` = 0, `cout` = 0 and `err` = 1. Every legal `op` yields `err` = 0.
- R7: During reset and right after it, `out_valid` is 0 and `in_ready` is 1.
- R8: An operation is accepted on an edge with `in_valid` and `in_ready` both high, and its result is shown with `out_valid` = 1 from the next cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `res`, `cout` and `err` hold steady. Results come out in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| a | input | W | First operand |
| b | input | W | Second operand |
| fcode | input | 4 | Truth table for logic mode (MSB = output for pair 00) |
| op | input | 2 | 00 add, 01 subtract, 10 logic, 11 illegal |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| res | output | W | Registered result |
| cout | output | 1 | Registered carry-out (no-borrow flag for subtract) |
| err | output | 1 | Registered illegal-operation flag |

## Verification
The assertions assume that the consumer follows the handshake: nothing counts as transferred unless `out_ready` is sampled high together with `out_valid`. They also assume that `op`, operands and code are settled at each rising edge. The stimulus changes every input only on the falling clock edge and drives `out_ready` randomly, so stalls of several cycles occur. The bench tracks acceptance and consumption separately, which exercises both the hold rule and the rule that a request can be accepted in the same cycle a result drains.

// File: rtl/pg_alu_pkg.sv
package pg_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_LOGIC = 2'b10,
    OP_BAD   = 2'b11
  } alu_op_e;

  localparam int unsigned LUT_ENTRIES = 4;

  function automatic logic op_is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/pg_alu_bitcell.sv
module pg_alu_bitcell
  import pg_alu_pkg::*;
(
  input  logic                   a_i,
  input  logic                   b_i,
  input  logic [LUT_ENTRIES-1:0] code_i,
  input  alu_op_e                op_i,
  output logic                   p_o,
  output logic                   g_o
);

  logic [1:0] idx;
  logic       lut_bit;

  assign idx     = {a_i, b_i};
  assign lut_bit = code_i[2'd3 - idx];

  always_comb begin
    unique case (op_i)
      OP_ADD: begin
        p_o = a_i ^ b_i;
        g_o = a_i & b_i;
      end
      OP_SUB: begin
        p_o = ~(a_i ^ b_i);
        g_o = a_i & ~b_i;
      end
      OP_LOGIC: begin
        p_o = lut_bit;
        g_o = 1'b0;
      end
      default: begin
        p_o = 1'b0;
        g_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pg_alu_carry.sv
module pg_alu_carry #(
  parameter int unsigned W = 16
) (
  input  logic         cin_i,
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] g_i,
  output logic [W-1:0] cbit_o,
  output logic         cout_o
);

  always_comb begin
    logic cy;
    cy = cin_i;
    for (int i = 0; i < W; i++) begin
      cbit_o[i] = cy;
      cy = g_i[i] | (p_i[i] & cy);
    end
    cout_o = cy;
  end

endmodule

// File: rtl/pg_alu_result.sv
module pg_alu_result
  import pg_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] cbit_i,
  input  logic         chain_cout_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         err_o
);

  logic [W-1:0] sum;

  for (genvar i = 0; i < W; i++) begin : g_xor
    assign sum[i] = p_i[i] ^ cbit_i[i];
  end

  always_comb begin
    err_o  = (op_i == OP_BAD);
    res_o  = err_o ? '0 : sum;
    cout_o = op_is_arith(op_i) ? chain_cout_i : 1'b0;
  end

endmodule

// File: rtl/pg_alu.sv
module pg_alu
  import pg_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   fcode,
  input  logic [1:0]   op,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         err
);

  alu_op_e      op_q;
  logic [W-1:0] p_vec;
  logic [W-1:0] g_vec;
  logic [W-1:0] cbit;
  logic         chain_cout;
  logic         cin;
  logic [W-1:0] res_d;
  logic         cout_d;
  logic         err_d;
  logic         accept;

  assign op_q = alu_op_e'(op);
  assign cin  = (op_q == OP_SUB);

  for (genvar i = 0; i < W; i++) begin : g_slice
    pg_alu_bitcell u_cell (
      .a_i    (a[i]),
      .b_i    (b[i]),
      .code_i (fcode),
      .op_i   (op_q),
      .p_o    (p_vec[i]),
      .g_o    (g_vec[i])
    );
  end

  pg_alu_carry #(.W(W)) u_chain (
    .cin_i  (cin),
    .p_i    (p_vec),
    .g_i    (g_vec),
    .cbit_o (cbit),
    .cout_o (chain_cout)
  );

  pg_alu_result #(.W(W)) u_result (
    .op_i         (op_q),
    .p_i          (p_vec),
    .cbit_i       (cbit),
    .chain_cout_i (chain_cout),
    .res_o        (res_d),
    .cout_o       (cout_d),
    .err_o        (err_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
      cout      <= 1'b0;
      err       <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      res       <= res_d;
      cout      <= cout_d;
      err       <= err_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: an accepted request is on show in the next cycle
  p_fire_then_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R8: a stalled result does not move
  p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res) && $stable(cout) && $stable(err)));

  // R6: an illegal-operation result carries no data and no carry
  p_bad_is_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && err) |-> (res == '0 && !cout));

  // R4: in logic mode the chain never produces a carry out of the top bit
  p_logic_nocarry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_LOGIC) |-> (!chain_cout && cbit == '0));

  // R7: an empty output register always leaves the input open
  p_empty_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

// File: tb/pg_alu_tb.sv
`timescale 1ns/1ps
module pg_alu_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [3:0]   fcode = '0;
  logic [1:0]   op = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] res;
  logic         cout;
  logic         err;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit run_en  = 1'b0;
  bit done    = 1'b0;

  logic [W-1:0] q_res[$];
  logic         q_cout[$];
  logic         q_err[$];
  string        q_tag[$];

  logic         st_prev;
  logic [W-1:0] st_res;
  logic         st_cout;
  logic         st_err;

  always #10 clk = ~clk;

  pg_alu #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a(a), .b(b), .fcode(fcode), .op(op), .out_valid(out_valid),
    .out_ready(out_ready), .res(res), .cout(cout), .err(err)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W:0] act, input logic [W:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [3:0] c, input logic [1:0] o);
    logic [W:0]   full;
    logic [W-1:0] r;
    logic         co;
    logic         e;
    string        t;
    r = '0; co = 1'b0; e = 1'b0;
    case (o)
      2'b00: begin
        full = {1'b0, x} + {1'b0, y};
        r = full[W-1:0]; co = full[W]; t = "R1/R5";
      end
      2'b01: begin
        r = x - y; co = (x >= y); t = "R2/R5";
      end
      2'b10: begin
        for (int i = 0; i < W; i++) begin
          case ({x[i], y[i]})
            2'b00: r[i] = c[3];
            2'b01: r[i] = c[2];
            2'b10: r[i] = c[1];
            default: r[i] = c[0];
          endcase
        end
        t = "R3/R4";
      end
      default: begin
        e = 1'b1; t = "R6";
      end
    endcase
    q_res.push_back(r); q_cout.push_back(co); q_err.push_back(e); q_tag.push_back(t);
  endtask

  // monitor: evaluate what the coming rising edge will transfer
  always @(negedge clk) begin
    #2;
    if (run_en) begin
      check(in_ready == (!out_valid || out_ready), "R8", "in_ready", {{W{1'b0}}, in_ready},
            {{W{1'b0}}, (!out_valid || out_ready)});
      if (st_prev) begin
        check(out_valid && res == st_res && cout == st_cout && err == st_err, "R8", "hold",
              {out_valid, res}, {1'b1, st_res});
      end
      st_prev = out_valid && !out_ready;
      st_res = res; st_cout = cout; st_err = err;
      if (out_valid && out_ready) begin
        if (q_res.size() == 0) begin
          check(1'b0, "R8", "unexpected result", {1'b0, res}, '0);
        end else begin
          logic [W-1:0] er;
          logic         ec;
          logic         ee;
          string        et;
          er = q_res.pop_front(); ec = q_cout.pop_front();
          ee = q_err.pop_front(); et = q_tag.pop_front();
          check(res == er, et, "res", {1'b0, res}, {1'b0, er});
          check(cout == ec, et, "cout", {{W{1'b0}}, cout}, {{W{1'b0}}, ec});
          check(err == ee, "R6", "err", {{W{1'b0}}, err}, {{W{1'b0}}, ee});
        end
      end
      if (in_valid && in_ready) model(a, b, fcode, op);
    end
  end

  // random back-pressure
  always @(negedge clk) begin
    if (run_en) out_ready <= (($urandom % 4) != 0);
  end

  task automatic send(input logic [W-1:0] x, input logic [W-1:0] y,
                      input logic [3:0] c, input logic [1:0] o);
    @(negedge clk);
    a = x; b = y; fcode = c; op = o; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    a = $urandom; b = $urandom; fcode = $urandom; op = $urandom;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    st_prev = 1'b0; st_res = '0; st_cout = 1'b0; st_err = 1'b0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(out_valid == 1'b0 && in_ready == 1'b1, "R7", "reset state",
          {{(W-1){1'b0}}, out_valid, in_ready}, {{(W-1){1'b0}}, 2'b01});
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R7", "after reset",
          {{(W-1){1'b0}}, out_valid, in_ready}, {{(W-1){1'b0}}, 2'b01});
    run_en = 1'b1;

    // R1 boundaries: overflow wrap, zeros
    send('1, 16'h0001, 4'h0, 2'b00);
    send('0, '0, 4'hF, 2'b00);
    send('1, '1, 4'h5, 2'b00);
    // R2 boundaries: equal, borrow, zero minus one
    send(16'h1234, 16'h1234, 4'h0, 2'b01);
    send(16'h0003, 16'h0007, 4'h0, 2'b01);
    send('0, 16'h0001, 4'h9, 2'b01);
    // R3 named codes: XOR, AND, OR
    send(16'hF0F0, 16'hCCCC, 4'b0110, 2'b10);
    send(16'hF0F0, 16'hCCCC, 4'b0001, 2'b10);
    send(16'hF0F0, 16'hCCCC, 4'b0111, 2'b10);
    // R6 illegal op
    send(16'hFFFF, 16'h0001, 4'hF, 2'b11);
    send(16'h1234, 16'h4321, 4'h6, 2'b11);
    // R3 and R4: every code with random operands
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 12; k++) send($urandom, $urandom, c[3:0], 2'b10);
    end
    // R1, R2 and R5: random arithmetic with random codes
    for (int k = 0; k < 200; k++) send($urandom, $urandom, $urandom, 2'b00);
    for (int k = 0; k < 200; k++) send($urandom, $urandom, $urandom, 2'b01);
    // R5: same operands, different codes
    for (int c = 0; c < 16; c++) send(16'hA5C3, 16'h5A3C, c[3:0], 2'b00);
    for (int c = 0; c < 16; c++) send(16'h5A3C, 16'hA5C3, c[3:0], 2'b01);
    // R8: back-to-back mixed stream
    for (int k = 0; k < 100; k++) send($urandom, $urandom, $urandom, $urandom);

    for (int k = 0; k < 200 && q_res.size() != 0; k++) @(negedge clk);
    check(q_res.size() == 0, "R8", "drain", q_res.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule